// File: doc/BRIEF.md
# Parallel Byte Transmitter with Four-Phase Handshake

This block sends bytes, one at a time, from a host over an eight-bit parallel link to a remote receiver. On the host side it takes a byte through a valid/ready pair. On the link side it drives eight data lines and an active-low strobe. It watches an active-low acknowledge line and an active-high busy line from the receiver, and both of those pass through two-flop synchronisers first.

A byte is taken only while the transmitter is idle and the receiver is not busy. The byte goes onto the data lines, and the data is held for a programmable setup interval. The strobe then falls and stays low for at least a programmable width, and it is kept low until acknowledge is seen active. After the strobe is released, the transmitter waits for acknowledge to go inactive before it can take the next byte. If either acknowledge wait runs longer than a programmable limit, the transmitter abandons the transfer, returns to idle and sets a sticky timeout flag.

Top module: `par_tx_handshake`

## Requirements
- R1: While reset is held and on the first cycle after it, strobeN is 1, linkData is 0, txActive is 0 and timeoutFlag is 0. inReady is 1 if linkBusy has been low.
- R2: ackN and linkBusy pass through a two-stage synchroniser. A change on either pin can affect the block no earlier than the second rising clock edge after the change.
- R3: inReady is 1 only when the block is idle and the synchronised busy is inactive. A byte is accepted on a rising edge where inValid and inReady are both 1.
- R4: The accepted byte appears on linkData at the accepting edge. strobeN falls exactly setupCycles+1 cycles later, and linkData does not change in between.
- R5: strobeN stays low for at least strobeCycles+1 cycles. It stays low until the synchronised acknowledge (ackN low) is seen, or until a timeout occurs.
- R6: After acknowledge is seen, strobeN returns high. The block returns to idle only after the synchronised acknowledge is inactive again (ackN high).
- R7: inData[i] drives linkData[i] for every i, in natural bit order. linkData holds the last accepted byte until the next accept.
- R8: If the wait for acknowledge active, or the wait for acknowledge inactive, lasts timeoutLimit+1 cycles without success, the block returns to idle with strobeN high and sets timeoutFlag.
- R9: Once set, timeoutFlag stays at 1 until reset, including across later successful transfers.
- R10: txActive is 1 from the cycle after an accept until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inData | input | DATA_W | Byte from the host |
| inValid | input | 1 | Host byte valid |
| inReady | output | 1 | Block can accept a byte |
| setupCycles | input | CNT_W | Data setup interval minus one, in cycles |
| strobeCycles | input | CNT_W | Minimum strobe width minus one, in cycles |
| timeoutLimit | input | WAIT_W | Acknowledge wait limit minus one, in cycles |
| linkData | output | DATA_W | Parallel data lines |
| strobeN | output | 1 | Active-low data strobe |
| ackN | input | 1 | Active-low acknowledge from receiver |
| linkBusy | input | 1 | Receiver busy, active high |
| txActive | output | 1 | Transfer in progress |
| timeoutFlag | output | 1 | Sticky acknowledge timeout |

## Verification
The assertions assume that the host holds setupCycles, strobeCycles and timeoutLimit constant while a transfer is in progress. They also assume the receiver keeps acknowledge low until it sees the strobe released, so a short glitch on acknowledge is never mistaken for a complete handshake. The bench meets both assumptions in three ways:
- It changes the timing settings only after txActive has fallen and acknowledge is back high.
- Its receiver model releases acknowledge only after strobeN has risen.
- In the timeout scenarios, acknowledge is driven directly and held at one level until the transfer has been abandoned.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_PULSE   = 3'd2,
    ST_ACKWAIT = 3'd3,
    ST_RELWAIT = 3'd4
  } ptxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic loadSetup;
    logic loadStrobe;
    logic countDown;
    logic clearWait;
    logic countWait;
  } ptxCtl_t;

endpackage

// File: rtl/ptx_sync.sv
module ptx_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/ptx_datapath.sv
module ptx_datapath
  import ptx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptxCtl_t           ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic [CNT_W-1:0]  setupCycles,
  input  logic [CNT_W-1:0]  strobeCycles,
  input  logic [WAIT_W-1:0] timeoutLimit,
  output logic [DATA_W-1:0] linkData,
  output logic              phaseZero,
  output logic              waitHit
);

  logic [DATA_W-1:0] dataReg;
  logic [CNT_W-1:0]  phaseCnt;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataReg <= '0;
    else if (ctl.loadData) dataReg <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               phaseCnt <= '0;
    else if (ctl.loadSetup)  phaseCnt <= setupCycles;
    else if (ctl.loadStrobe) phaseCnt <= strobeCycles;
    else if (ctl.countDown)  phaseCnt <= phaseCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              waitCnt <= '0;
    else if (ctl.clearWait) waitCnt <= '0;
    else if (ctl.countWait) waitCnt <= waitCnt + 1'b1;
  end

  assign linkData  = dataReg;
  assign phaseZero = (phaseCnt == '0);
  assign waitHit   = (waitCnt == timeoutLimit);

endmodule

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
  import ptx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    busySeen,
  input  logic    ackSeen,
  input  logic    phaseZero,
  input  logic    waitHit,
  output ptxCtl_t ctl,
  output logic    inReady,
  output logic    strobeN,
  output logic    txActive,
  output logic    timeoutFlag
);

  ptxState_e state, stateNext;
  logic      raiseTimeout;

  assign inReady  = (state == ST_IDLE) && !busySeen;
  assign strobeN  = !((state == ST_PULSE) || (state == ST_ACKWAIT));
  assign txActive = (state != ST_IDLE);

  always_comb begin
    ctl          = '0;
    stateNext    = state;
    raiseTimeout = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (inValid && inReady) begin
          ctl.loadData  = 1'b1;
          ctl.loadSetup = 1'b1;
          stateNext     = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (phaseZero) begin
          ctl.loadStrobe = 1'b1;
          stateNext      = ST_PULSE;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      ST_PULSE: begin
        if (phaseZero) begin
          ctl.clearWait = 1'b1;
          stateNext     = ST_ACKWAIT;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      ST_ACKWAIT: begin
        if (ackSeen) begin
          ctl.clearWait = 1'b1;
          stateNext     = ST_RELWAIT;
        end else if (waitHit) begin
          raiseTimeout = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          ctl.countWait = 1'b1;
        end
      end
      ST_RELWAIT: begin
        if (!ackSeen) begin
          stateNext = ST_IDLE;
        end else if (waitHit) begin
          raiseTimeout = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          ctl.countWait = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timeoutFlag <= 1'b0;
    else if (raiseTimeout) timeoutFlag <= 1'b1;
  end

endmodule

// File: rtl/par_tx_handshake.sv
module par_tx_handshake
  import ptx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CNT_W-1:0]  setupCycles,
  input  logic [CNT_W-1:0]  strobeCycles,
  input  logic [WAIT_W-1:0] timeoutLimit,
  output logic [DATA_W-1:0] linkData,
  output logic              strobeN,
  input  logic              ackN,
  input  logic              linkBusy,
  output logic              txActive,
  output logic              timeoutFlag
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] rawIn, syncOut;
  logic              ackSeen, busySeen;
  logic              phaseZero, waitHit;
  ptxCtl_t           ctl;

  assign rawIn    = {linkBusy, ~ackN};
  assign ackSeen  = syncOut[0];
  assign busySeen = syncOut[1];

  ptx_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncOut)
  );

  ptx_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .busySeen    (busySeen),
    .ackSeen     (ackSeen),
    .phaseZero   (phaseZero),
    .waitHit     (waitHit),
    .ctl         (ctl),
    .inReady     (inReady),
    .strobeN     (strobeN),
    .txActive    (txActive),
    .timeoutFlag (timeoutFlag)
  );

  ptx_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .inData       (inData),
    .setupCycles  (setupCycles),
    .strobeCycles (strobeCycles),
    .timeoutLimit (timeoutLimit),
    .linkData     (linkData),
    .phaseZero    (phaseZero),
    .waitHit      (waitHit)
  );

endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] linkData,
  input logic              strobeN,
  input logic              txActive,
  input logic              timeoutFlag,
  input logic              ackSeen,
  input logic              busySeen
);

  assert_ready_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!txActive && !busySeen));

  assert_data_only_on_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(linkData) |-> $past(inValid && inReady));

  assert_data_held_in_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeN && !$past(strobeN)) |-> $stable(linkData));

  assert_strobe_in_transfer_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> txActive);

  assert_release_after_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeN) |-> (!txActive || $past(ackSeen)));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(timeoutFlag) |-> timeoutFlag);

  assert_flag_goes_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (!txActive && strobeN));

endmodule

bind par_tx_handshake ptx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .inReady     (inReady),
  .linkData    (linkData),
  .strobeN     (strobeN),
  .txActive    (txActive),
  .timeoutFlag (timeoutFlag),
  .ackSeen     (ackSeen),
  .busySeen    (busySeen)
);

// File: tb/par_tx_handshake_bench.sv
`timescale 1ns/1ps
module par_tx_handshake_bench;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int WAIT_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [CNT_W-1:0]  setupCycles = '0;
  logic [CNT_W-1:0]  strobeCycles = '0;
  logic [WAIT_W-1:0] timeoutLimit = 16'd20;
  logic [DATA_W-1:0] linkData;
  logic              strobeN;
  logic              ackN = 1'b1;
  logic              linkBusy = 1'b0;
  logic              txActive;
  logic              timeoutFlag;

  always #2 clk = ~clk;

  par_tx_handshake #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_par_tx_handshake (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .setupCycles(setupCycles), .strobeCycles(strobeCycles), .timeoutLimit(timeoutLimit),
    .linkData(linkData), .strobeN(strobeN), .ackN(ackN), .linkBusy(linkBusy),
    .txActive(txActive), .timeoutFlag(timeoutFlag)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Behavioural reference: phase 0 idle,1 setup,2 strobe min,3 wait ack,4 wait release
  int mPhase = 0, mCnt = 0, mWait = 0;
  int mData = 0;
  bit mFlag = 0;
  bit aPipe1 = 0, aPipe2 = 0, bPipe1 = 0, bPipe2 = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mWait = 0; mData = 0; mFlag = 0;
      aPipe1 = 0; aPipe2 = 0; bPipe1 = 0; bPipe2 = 0;
    end else begin
      bit rdy;
      rdy = (mPhase == 0) && !bPipe2;
      case (mPhase)
        0: if (inValid && rdy) begin mData = inData; mCnt = setupCycles; mPhase = 1; end
        1: if (mCnt == 0) begin mCnt = strobeCycles; mPhase = 2; end else mCnt--;
        2: if (mCnt == 0) begin mWait = 0; mPhase = 3; end else mCnt--;
        3: if (aPipe2) begin mWait = 0; mPhase = 4; end
           else if (mWait == timeoutLimit) begin mFlag = 1; mPhase = 0; end
           else mWait++;
        default: if (!aPipe2) mPhase = 0;
           else if (mWait == timeoutLimit) begin mFlag = 1; mPhase = 0; end
           else mWait++;
      endcase
      aPipe2 = aPipe1; aPipe1 = !ackN;
      bPipe2 = bPipe1; bPipe1 = linkBusy;
    end
  end

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit eStrobeN, eReady, eActive;
      eStrobeN = !(mPhase == 2 || mPhase == 3);
      eReady   = (mPhase == 0) && !bPipe2;
      eActive  = (mPhase != 0);
      check(strobeN == eStrobeN, "R5 strobeN", strobeN, eStrobeN);
      check(linkData == mData[7:0], "R7 linkData", linkData, mData);
      check(inReady == eReady, "R3 inReady", inReady, eReady);
      check(txActive == eActive, "R10 txActive", txActive, eActive);
      check(timeoutFlag == mFlag, "R8 timeoutFlag", timeoutFlag, mFlag);
    end
  end

  // Receiver model
  bit respEn = 1;
  int ackDly = 1, relDly = 1;
  logic [7:0] rxQ[$];

  initial begin
    forever begin
      @(negedge clk);
      if (respEn && rstN && !strobeN) begin
        rxQ.push_back(linkData);
        repeat (ackDly) @(negedge clk);
        ackN = 1'b0;
        while (!strobeN) @(negedge clk);
        repeat (relDly) @(negedge clk);
        ackN = 1'b1;
      end
    end
  end

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inData  = b;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    do begin @(negedge clk); guard++; end while ((txActive || !ackN) && guard < 2000);
    repeat (3) @(negedge clk);
  endtask

  task automatic runBytes(input int su, input int sw, input int ad, input int rd);
    logic [7:0] pat [5] = '{8'hA5, 8'h5A, 8'hFF, 8'h01, 8'h80};
    setupCycles = su[CNT_W-1:0]; strobeCycles = sw[CNT_W-1:0]; ackDly = ad; relDly = rd;
    rxQ.delete();
    foreach (pat[i]) begin
      sendByte(pat[i]);
      waitIdle();
    end
    check(rxQ.size() == 5, "R6 byte count", rxQ.size(), 5);
    foreach (pat[i]) if (i < rxQ.size())
      check(rxQ[i] == pat[i], "R7 bit order", rxQ[i], pat[i]);
  endtask

  // Setup and strobe width measured directly at the pins
  task automatic measureTiming(input int su, input int sw);
    int cs = 0, cw = 0;
    setupCycles = su[CNT_W-1:0]; strobeCycles = sw[CNT_W-1:0]; ackDly = 0; relDly = 0;
    @(negedge clk);
    inData = 8'h3C; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk); inValid = 1'b0;
    while (strobeN) begin cs++; @(negedge clk); end
    check(cs == su + 1, "R4 setup cycles", cs, su + 1);
    while (!strobeN) begin cw++; @(negedge clk); end
    check(cw >= sw + 1, "R5 strobe width", cw, sw + 1);
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(strobeN == 1'b1, "R1 strobeN", strobeN, 1);
    check(linkData == 8'h00, "R1 linkData", linkData, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1 && txActive == 1'b0 && timeoutFlag == 1'b0, "R1 status",
          {inReady, txActive, timeoutFlag}, 3'b100);

    runBytes(0, 0, 0, 0);
    runBytes(3, 5, 2, 4);
    runBytes(7, 2, 6, 1);
    measureTiming(4, 3);
    measureTiming(0, 6);

    // Busy gating, R2/R3
    setupCycles = 1; strobeCycles = 1; ackDly = 1; relDly = 1;
    @(negedge clk); linkBusy = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R2 busy not yet synced", inReady, 1);
    repeat (2) @(negedge clk);
    check(inReady == 1'b0, "R3 ready low while busy", inReady, 0);
    fork
      begin
        repeat (6) @(negedge clk);
        check(txActive == 1'b0, "R3 no accept while busy", txActive, 0);
        linkBusy = 1'b0;
      end
    join_none
    rxQ.delete();
    sendByte(8'hC3);
    waitIdle();
    check(rxQ.size() == 1 && rxQ[0] == 8'hC3, "R3 byte after busy", rxQ.size(), 1);

    // Acknowledge never comes, R8
    respEn = 0; timeoutLimit = 16'd12;
    sendByte(8'h77);
    waitIdle();
    check(timeoutFlag == 1'b1, "R8 ack timeout flag", timeoutFlag, 1);
    check(strobeN == 1'b1, "R8 strobe released", strobeN, 1);

    // Sticky across a good transfer, R9
    respEn = 1;
    sendByte(8'h11);
    waitIdle();
    check(timeoutFlag == 1'b1, "R9 flag sticky", timeoutFlag, 1);

    // Acknowledge stuck active, R6/R8
    respEn = 0;
    sendByte(8'h99);
    while (strobeN) @(negedge clk);
    repeat (3) @(negedge clk);
    ackN = 1'b0;
    while (!strobeN) @(negedge clk);
    check(txActive == 1'b1, "R6 waits for ack release", txActive, 1);
    begin
      int g = 0;
      while (txActive && g < 200) begin @(negedge clk); g++; end
    end
    check(txActive == 1'b0 && ackN == 1'b0, "R8 release timeout", txActive, 0);
    ackN = 1'b1;
    repeat (4) @(negedge clk);
    respEn = 1;
    rxQ.delete();
    sendByte(8'h42);
    waitIdle();
    check(rxQ.size() == 1 && rxQ[0] == 8'h42, "R6 recovers after timeout", rxQ.size(), 1);

    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

endmodule